// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Decimal Adjust

This block is the purely combinational arithmetic and logic stage of a small accumulator-based processor. In the same evaluation it takes the accumulator, a second operand, the current flag byte and a 4-bit operation code. It returns an 8-bit result, the updated flag byte, and a write enable. The write enable tells the surrounding datapath whether the result should be written back.

Each operation sets its own flags. Some flags are computed, some are forced to a constant and some are passed through unchanged. The half-carry and carry flags from an earlier add or subtract feed the decimal-adjust operation. That operation uses them, together with the subtract flag, to turn a binary sum or difference of packed BCD values into valid BCD.

The block has no clock and no handshake. Operand fetch, memory access, register storage and instruction decoding sit outside it.

Top module: `acc_alu`

## Requirements
- R1: The operation codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 OR, 7 XOR, 8 complement, 9 increment, 10 decrement, 11 set carry, 12 complement carry and 13 decimal adjust. The write enable is 1 for every code except 4, 11, 12, 14 and 15. Whenever the write enable is 0, the result equals the accumulator.
- R2: The flag byte (input and output) holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Output bits 3..0 are always 0, and input bits 3..0 have no effect.
- R3: Add and add-with-carry (carry-in is input C, for code 1 only) clear N. They set H on a carry out of bit 3, set C on a carry out of bit 7, and set Z when the 8-bit result is zero.
- R4: Subtract and subtract-with-borrow (borrow-in is input C, for code 3 only) set N. They set H when the low nibble of the operand plus the borrow exceeds the low nibble of the accumulator. They set C when the operand plus the borrow exceeds the accumulator. Z is set on a zero result.
- R5: Compare produces exactly the flags of subtract, and the result output stays equal to the accumulator.
- R6: AND gives H=1 and C=0. OR and XOR give H=0 and C=0. All three clear N and set Z from the result.
- R7: Complement outputs the bitwise inverse of the accumulator. It sets N and H and leaves Z and C unchanged.
- R8: Increment and decrement act on the operand input, not on the accumulator, and leave C unchanged. Increment clears N and sets H on a carry out of bit 3. Decrement sets N and sets H on a borrow into bit 4. Both set Z from the result.
- R9: Set-carry forces C=1 and complement-carry inverts C. Both clear N and H and keep Z.
- R10: Decimal adjust with input N=1 forms a correction of 0x06 if H is set, plus 0x60 if C is set. It subtracts the correction from the accumulator, and C is set when the correction exceeds the accumulator.
- R11: Decimal adjust with input N=0 adds 0x06 if H is set or the low nibble exceeds 9. It adds 0x60 if C is set or the accumulator exceeds 0x9F. C is the carry out of bit 7.
- R12: Decimal adjust always clears H, keeps N and sets Z from the result.
- R13: Codes 14 and 15 pass the accumulator through and return the input flags with bits 3..0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand; the target of increment and decrement |
| flags_i | input | 8 | Current flag byte (Z7 N6 H5 C4) |
| op_i | input | 4 | Operation code |
| result_o | output | 8 | Operation result |
| flags_o | output | 8 | Updated flag byte |
| wr_en_o | output | 1 | Result should be written back |

## Verification
The directed tests target the nibble and byte boundaries where the carry and borrow chains flip: 0x0F+1, 0xFF+1, 0x10-1, and a borrow-in that wraps 0x10-0x10-1 to 0xFF. A design that took H from the wrong bit or ignored the borrow-in would report the wrong H or C flag at those points. Decimal adjust is exercised at the 0x9F/0xA0 threshold and with a subtract correction that underflows, where a wrong compare threshold or a lost borrow shows up as a wrong result or carry. The checks also cover the flags that must pass through unchanged: C through increment and decrement, Z through complement and the carry operations, and N through decimal adjust. A design that cleared or recomputed any of these would be caught. A broad sweep of operand pairs, carry-ins and flag patterns compares every code, including the reserved ones, against an independent model.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 4;

  // Positions inside the flag byte; the neighbouring datapath decodes these.
  localparam int FZ = 7;
  localparam int FN = 6;
  localparam int FH = 5;
  localparam int FC = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_CPL  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_SCF  = 4'd11,
    OP_CCF  = 4'd12,
    OP_DAA  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } logic_sel_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flag_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W  = 8,
  parameter int NW = W / 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         half_o
);

  localparam logic [W:0]  ZEXT_W  = '0;
  localparam logic [NW:0] ZEXT_NW = '0;

  logic [W:0]  full;
  logic [NW:0] low;
  logic [W:0]  cin_w;
  logic [NW:0] cin_n;

  always_comb begin
    cin_w = ZEXT_W;
    cin_w[0] = cin_i;
    cin_n = ZEXT_NW;
    cin_n[0] = cin_i;
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - cin_w;
      low  = {1'b0, a_i[NW-1:0]} - {1'b0, b_i[NW-1:0]} - cin_n;
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + cin_w;
      low  = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]} + cin_n;
    end
  end

  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
  assign half_o = low[NW];

  // Inverse relation: undoing the operation must give back the accumulator.
  always_comb begin
    if (sub_i)
      AST_SUB_INVERTS: assert (W'(sum_o + b_i + W'(cin_i)) == a_i); // R4
    else
      AST_ADD_INVERTS: assert (W'(sum_o - b_i - W'(cin_i)) == a_i); // R3
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);

  always_comb begin
    unique case (sel_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~a_i;
    endcase
  end

  assign zero_o = (y_o == '0);

  always_comb begin
    if (sel_i == LG_AND)
      AST_AND_SUBSET: assert ((y_o & ~a_i) == '0); // R6
  end

endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd #(
  parameter int W  = 8,
  parameter int NW = W / 2
) (
  input  logic [W-1:0] a_i,
  input  logic         n_i,
  input  logic         h_i,
  input  logic         c_i,
  output logic [W-1:0] y_o,
  output logic         c_o,
  output logic         z_o
);

  localparam logic [NW-1:0] NIB_MAX  = NW'(9);
  localparam logic [W-1:0]  LOW_FIX  = W'(6);
  localparam logic [W-1:0]  HIGH_FIX = W'(8'h60);
  localparam logic [W-1:0]  HIGH_LIM = W'(8'h9F);

  logic          fix_low;
  logic          fix_high;
  logic [W-1:0]  corr;
  logic          unused_half;

  always_comb begin
    if (n_i) begin
      fix_low  = h_i;
      fix_high = c_i;
    end else begin
      fix_low  = h_i || (a_i[NW-1:0] > NIB_MAX);
      fix_high = c_i || (a_i > HIGH_LIM);
    end
    corr = (fix_low ? LOW_FIX : '0) | (fix_high ? HIGH_FIX : '0);
  end

  acc_alu_addsub #(.W(W), .NW(NW)) u_corr (
    .a_i    (a_i),
    .b_i    (corr),
    .cin_i  (1'b0),
    .sub_i  (n_i),
    .sum_o  (y_o),
    .cout_o (c_o),
    .half_o (unused_half)
  );

  assign z_o = (y_o == '0);

  always_comb begin
    if (n_i && !h_i && !c_i)
      AST_BCD_SUB_IDLE: assert (y_o == a_i && !c_o); // R10
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  input  logic [3:0] op_i,
  output logic [7:0] result_o,
  output logic [7:0] flags_o,
  output logic       wr_en_o
);

  alu_op_e    op;
  flag_t      fin;
  flag_t      fout;
  logic       is_step;
  logic [DATA_W-1:0] as_a;
  logic [DATA_W-1:0] as_b;
  logic       as_cin;
  logic       as_sub;
  logic [DATA_W-1:0] as_sum;
  logic       as_cout;
  logic       as_half;
  logic_sel_e lg_sel;
  logic [DATA_W-1:0] lg_y;
  logic       lg_zero;
  logic [DATA_W-1:0] bcd_y;
  logic       bcd_c;
  logic       bcd_z;

  assign op  = alu_op_e'(op_i);
  assign fin = '{z: flags_i[FZ], n: flags_i[FN], h: flags_i[FH], c: flags_i[FC]};

  // Shared add/subtract path: accumulator ops and operand step ops.
  assign is_step = (op == OP_INC) || (op == OP_DEC);
  assign as_a    = is_step ? opnd_i : acc_i;
  assign as_b    = is_step ? DATA_W'(1) : opnd_i;
  assign as_cin  = ((op == OP_ADC) || (op == OP_SBC)) ? fin.c : 1'b0;
  assign as_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);

  acc_alu_addsub #(.W(DATA_W), .NW(NIB_W)) u_addsub (
    .a_i    (as_a),
    .b_i    (as_b),
    .cin_i  (as_cin),
    .sub_i  (as_sub),
    .sum_o  (as_sum),
    .cout_o (as_cout),
    .half_o (as_half)
  );

  always_comb begin
    unique case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_NOT;
    endcase
  end

  acc_alu_logic #(.W(DATA_W)) u_logic (
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .sel_i  (lg_sel),
    .y_o    (lg_y),
    .zero_o (lg_zero)
  );

  acc_alu_bcd #(.W(DATA_W), .NW(NIB_W)) u_bcd (
    .a_i (acc_i),
    .n_i (fin.n),
    .h_i (fin.h),
    .c_i (fin.c),
    .y_o (bcd_y),
    .c_o (bcd_c),
    .z_o (bcd_z)
  );

  always_comb begin
    result_o = acc_i;
    wr_en_o  = 1'b0;
    fout     = fin;
    unique case (op)
      OP_ADD, OP_ADC: begin
        result_o = as_sum;
        wr_en_o  = 1'b1;
        fout     = '{z: (as_sum == '0), n: 1'b0, h: as_half, c: as_cout};
      end
      OP_SUB, OP_SBC: begin
        result_o = as_sum;
        wr_en_o  = 1'b1;
        fout     = '{z: (as_sum == '0), n: 1'b1, h: as_half, c: as_cout};
      end
      OP_CMP: begin
        fout     = '{z: (as_sum == '0), n: 1'b1, h: as_half, c: as_cout};
      end
      OP_AND: begin
        result_o = lg_y;
        wr_en_o  = 1'b1;
        fout     = '{z: lg_zero, n: 1'b0, h: 1'b1, c: 1'b0};
      end
      OP_OR, OP_XOR: begin
        result_o = lg_y;
        wr_en_o  = 1'b1;
        fout     = '{z: lg_zero, n: 1'b0, h: 1'b0, c: 1'b0};
      end
      OP_CPL: begin
        result_o = lg_y;
        wr_en_o  = 1'b1;
        fout     = '{z: fin.z, n: 1'b1, h: 1'b1, c: fin.c};
      end
      OP_INC: begin
        result_o = as_sum;
        wr_en_o  = 1'b1;
        fout     = '{z: (as_sum == '0), n: 1'b0, h: as_half, c: fin.c};
      end
      OP_DEC: begin
        result_o = as_sum;
        wr_en_o  = 1'b1;
        fout     = '{z: (as_sum == '0), n: 1'b1, h: as_half, c: fin.c};
      end
      OP_SCF: begin
        fout     = '{z: fin.z, n: 1'b0, h: 1'b0, c: 1'b1};
      end
      OP_CCF: begin
        fout     = '{z: fin.z, n: 1'b0, h: 1'b0, c: ~fin.c};
      end
      OP_DAA: begin
        result_o = bcd_y;
        wr_en_o  = 1'b1;
        fout     = '{z: bcd_z, n: fin.n, h: 1'b0, c: bcd_c};
      end
      default: begin
        result_o = acc_i;
        wr_en_o  = 1'b0;
        fout     = fin;
      end
    endcase
  end

  assign flags_o = {fout.z, fout.n, fout.h, fout.c, 4'b0000};

  always_comb begin
    if (!wr_en_o)
      AST_HOLD_ACC: assert (result_o == acc_i); // R1
    if (is_step)
      AST_STEP_KEEPS_C: assert (flags_o[FC] == flags_i[FC]); // R8
    if (op == OP_CMP)
      AST_CMP_NEEDS_SUB: assert (as_sub && !wr_en_o); // R5
    if (op == OP_DAA)
      AST_DAA_KEEPS_N: assert (flags_o[FN] == flags_i[FN] && !flags_o[FH]); // R12
  end

endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] acc, opnd, fl_in;
  logic [3:0] op;
  logic [7:0] res, fl_out;
  logic       we;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  acc_alu i_acc_alu (
    .acc_i    (acc),
    .opnd_i   (opnd),
    .flags_i  (fl_in),
    .op_i     (op),
    .result_o (res),
    .flags_o  (fl_out),
    .wr_en_o  (we)
  );

  task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] f);
    op = o; acc = a; opnd = b; fl_in = f;
    #2;
  endtask

  task automatic check(input string tag, input logic e_we, input logic [7:0] e_res,
                       input logic [7:0] e_fl);
    n_cmp++;
    if (we !== e_we || res !== e_res || fl_out !== e_fl) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h : got we=%b res=%02h fl=%02h exp we=%b res=%02h fl=%02h",
               tag, op, acc, opnd, fl_in, we, res, fl_out, e_we, e_res, e_fl);
    end
  endtask

  // Behavioural model built from the requirements.
  function automatic logic [16:0] model(input logic [3:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] f);
    int x, y, cin, adj, r;
    logic z, n, h, c, w;
    logic [7:0] out;
    z = f[7]; n = f[6]; h = f[5]; c = f[4];
    x = a; y = b; w = 1'b1; out = a;
    cin = (o == 1 || o == 3) ? int'(c) : 0;
    case (o)
      0, 1: begin
        r = x + y + cin; out = r[7:0];
        z = (out == 0); n = 0; h = ((x % 16) + (y % 16) + cin) > 15; c = r > 255;
      end
      2, 3, 4: begin
        r = x - y - cin; out = r[7:0];
        z = (out == 0); n = 1; h = ((y % 16) + cin) > (x % 16); c = (y + cin) > x;
        if (o == 4) begin out = a; w = 0; end
      end
      5: begin out = a & b; z = (out == 0); n = 0; h = 1; c = 0; end
      6: begin out = a | b; z = (out == 0); n = 0; h = 0; c = 0; end
      7: begin out = a ^ b; z = (out == 0); n = 0; h = 0; c = 0; end
      8: begin out = ~a; n = 1; h = 1; end
      9: begin r = y + 1; out = r[7:0]; z = (out == 0); n = 0; h = (y % 16) == 15; end
      10: begin r = y - 1; out = r[7:0]; z = (out == 0); n = 1; h = (y % 16) == 0; end
      11: begin w = 0; n = 0; h = 0; c = 1; end
      12: begin w = 0; n = 0; h = 0; c = ~c; end
      13: begin
        adj = 0;
        if (n) begin
          if (h) adj += 6;
          if (c) adj += 96;
          r = x - adj; c = adj > x;
        end else begin
          if (h || (x % 16) > 9) adj += 6;
          if (c || x > 159) adj += 96;
          r = x + adj; c = r > 255;
        end
        out = r[7:0]; z = (out == 0); h = 0;
      end
      default: begin w = 0; end
    endcase
    return {w, out, z, n, h, c, 4'b0000};
  endfunction

  task automatic t_idle;  // R1 R13: all-zero inputs give a plain add of zeros
    apply(4'd0, 8'h00, 8'h00, 8'h00);
    check("R3 zero add", 1'b1, 8'h00, 8'h80);
    apply(4'd14, 8'h55, 8'h12, 8'hAF);
    check("R13 reserved 14", 1'b0, 8'h55, 8'hA0);
    apply(4'd15, 8'hC3, 8'h00, 8'h5F);
    check("R13 reserved 15", 1'b0, 8'hC3, 8'h50);
  endtask

  task automatic t_add;
    apply(4'd0, 8'h3A, 8'hC6, 8'h0F);
    check("R3 R2 add wrap", 1'b1, 8'h00, 8'hB0);
    apply(4'd1, 8'h0F, 8'h00, 8'h10);
    check("R3 adc half", 1'b1, 8'h10, 8'h20);
    apply(4'd0, 8'h0F, 8'h00, 8'h10);
    check("R3 add ignores C", 1'b1, 8'h0F, 8'h00);
  endtask

  task automatic t_sub;
    apply(4'd2, 8'h3E, 8'h3E, 8'h00);
    check("R4 sub zero", 1'b1, 8'h00, 8'hC0);
    apply(4'd2, 8'h3E, 8'h0F, 8'h00);
    check("R4 sub half", 1'b1, 8'h2F, 8'h60);
    apply(4'd3, 8'h10, 8'h10, 8'h10);
    check("R4 sbc wrap", 1'b1, 8'hFF, 8'h70);
  endtask

  task automatic t_cmp;
    apply(4'd4, 8'h3C, 8'h40, 8'h00);
    check("R5 R1 cmp borrow", 1'b0, 8'h3C, 8'h50);
    apply(4'd4, 8'h3C, 8'h3C, 8'h30);
    check("R5 cmp equal", 1'b0, 8'h3C, 8'hC0);
  endtask

  task automatic t_logic;
    apply(4'd5, 8'hF0, 8'h0F, 8'h5F);
    check("R6 and zero", 1'b1, 8'h00, 8'hA0);
    apply(4'd6, 8'h00, 8'h00, 8'h70);
    check("R6 or zero", 1'b1, 8'h00, 8'h80);
    apply(4'd7, 8'hFF, 8'h0F, 8'hF0);
    check("R6 xor", 1'b1, 8'hF0, 8'h00);
    apply(4'd8, 8'h35, 8'h00, 8'h90);
    check("R7 complement", 1'b1, 8'hCA, 8'hF0);
  endtask

  task automatic t_step;
    apply(4'd9, 8'hAA, 8'h0F, 8'h10);
    check("R8 inc half keeps C", 1'b1, 8'h10, 8'h30);
    apply(4'd9, 8'hAA, 8'hFF, 8'h00);
    check("R8 inc wrap", 1'b1, 8'h00, 8'hA0);
    apply(4'd10, 8'hAA, 8'h10, 8'h10);
    check("R8 dec borrow", 1'b1, 8'h0F, 8'h70);
    apply(4'd10, 8'hAA, 8'h01, 8'h00);
    check("R8 dec zero", 1'b1, 8'h00, 8'hC0);
  endtask

  task automatic t_carry;
    apply(4'd11, 8'h21, 8'h00, 8'hE0);
    check("R9 scf", 1'b0, 8'h21, 8'h90);
    apply(4'd12, 8'h21, 8'h00, 8'h90);
    check("R9 ccf", 1'b0, 8'h21, 8'h80);
  endtask

  task automatic t_daa;
    apply(4'd13, 8'h3C, 8'h00, 8'h00);
    check("R11 daa low fix", 1'b1, 8'h42, 8'h00);
    apply(4'd13, 8'hA0, 8'h00, 8'h00);
    check("R11 daa high wrap", 1'b1, 8'h00, 8'h90);
    apply(4'd13, 8'h2D, 8'h00, 8'h60);
    check("R10 R12 daa sub half", 1'b1, 8'h27, 8'h40);
    apply(4'd13, 8'h05, 8'h00, 8'h70);
    check("R10 daa sub borrow", 1'b1, 8'h9F, 8'h50);
  endtask

  task automatic t_sweep;  // R1..R13 against the model
    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 17)
          for (int ci = 0; ci < 2; ci++) begin
            logic [7:0] fa, fb, ff;
            logic [16:0] e;
            fa = 8'(a); fb = 8'(b);
            ff = {fb[7] ^ fa[3], fa[6], fb[2] ^ fa[0], 1'(ci), fa[3:0] ^ fb[3:0]};
            apply(4'(o), fa, fb, ff);
            e = model(4'(o), fa, fb, ff);
            check("R1-13 sweep", e[16], e[15:8], e[7:0]);
          end
  endtask

  initial begin
    acc = '0; opnd = '0; fl_in = '0; op = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_idle;
    t_add;
    t_sub;
    t_cmp;
    t_logic;
    t_step;
    t_carry;
    t_daa;
    t_sweep;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule